// File: doc/BRIEF.md
# Twin-Predicated Compress-Expand Sequencer

This block generates the element schedule for a single-source, single-destination vector operation, such as a move, a width conversion or an address generation. A start pulse supplies the vector length (VL), a base register and a vector/scalar flag for each side, and a separate predicate mask for the source and for the destination. The block then keeps two element counters of its own. On each side that is a vector, the counter jumps to the next enabled mask bit. The block hands the matched (source, destination) pairs, one per accepted handshake, to a downstream execution unit. Each pair comes with the element indices and the resulting register numbers.

The source mask selects which elements are read, which compresses them. The destination mask selects where the results land, which expands them. Both happen in one ordered pass. With an all-ones mask on one side the pass becomes a plain expand or a plain compress. With a scalar side and a single set bit on the other side, it becomes an insert, an extract or a broadcast. The sequence ends on its own, and a one-cycle completion pulse reports the end.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset the block is idle: busy_o, xfer_valid_o and done_o are all 0.
- R2: A start pulse is taken only while busy_o is 0. It captures VL, both flags, both bases and both masks. A start pulse and changed inputs while busy_o is 1 have no effect on the transfers of the run in progress.
- R3: With a vector source, the source index of each transfer is the lowest set source-mask bit at or above one past the previous transfer's source index. For the first transfer the search starts at 0. The index is always below VL.
- R4: With a vector destination, the destination index follows the same rule over the destination mask. The indices strictly increase within a run.
- R5: With a scalar source, every transfer uses source index 0 and the source mask is ignored.
- R6: With a scalar destination, the run issues exactly one transfer with destination index 0, and done_o follows in the next cycle.
- R7: The run ends without another transfer as soon as either vector side finds no set mask bit below VL. Mask bits at positions VL and above are never used, so a run may issue zero transfers.
- R8: While xfer_valid_o is 1 and xfer_ready_i is 0, the offered transfer stays valid and its indices and registers do not change. A transfer counts only on a cycle with both signals at 1.
- R9: done_o is a single-cycle pulse at the end of each run. In the cycle after the pulse, busy_o is 0.
- R10: The register outputs equal base plus element index, taken modulo 2^REG_W (128 by default), so that a run may wrap past the top register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (taken when idle) |
| vl_i | input | 7 | Vector length, 1 to 64 |
| src_vec_i | input | 1 | Source is a vector when 1 |
| dst_vec_i | input | 1 | Destination is a vector when 1 |
| src_base_i | input | 7 | Source base register |
| dst_base_i | input | 7 | Destination base register |
| src_mask_i | input | 64 | Source predicate, bit k enables element k |
| dst_mask_i | input | 64 | Destination predicate, bit k enables element k |
| xfer_ready_i | input | 1 | Downstream accepts the offered transfer |
| xfer_valid_o | output | 1 | A transfer is offered |
| src_idx_o | output | 6 | Source element index |
| dst_idx_o | output | 6 | Destination element index |
| src_reg_o | output | 7 | Source register number |
| dst_reg_o | output | 7 | Destination register number |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
On every cycle, the assertions check the following:
- an offered vector-side index always lands on a set bit of the captured mask, below VL;
- a scalar source stays on element 0;
- a stalled offer holds still;
- destination indices climb within a run;
- a scalar destination finishes right after its one transfer;
- the captured run state is not disturbed while busy.

Only the bench scenarios can show that no enabled element is skipped, and that the number of transfers per run is exactly right. The scenarios compare whole transfer sequences against a model for compress, expand, twin-mask, full-length, insert/extract, zero-transfer and wrap-around cases.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } tps_state_e;

endpackage

// File: rtl/tps_scan.sv
// Next-enabled-element search for one side of the sequencer.
// Vector side: lowest set mask bit in [from, lim). Scalar side: the
// current position itself, valid while below lim.
module tps_scan #(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = $clog2(MAX_VL + 1)
) (
  input  logic              vec_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [CNT_W-1:0]  from_i,
  input  logic [CNT_W-1:0]  lim_i,
  output logic              ok_o,
  output logic [CNT_W-1:0]  idx_o
);

  logic [MAX_VL-1:0] window;

  always_comb begin
    for (int k = 0; k < MAX_VL; k++) begin
      window[k] = mask_i[k] && (k >= int'(from_i)) && (k < int'(lim_i));
    end
  end

  always_comb begin
    ok_o  = 1'b0;
    idx_o = from_i;
    if (!vec_i) begin
      ok_o  = (from_i < lim_i);
      idx_o = from_i;
    end else begin
      for (int k = MAX_VL - 1; k >= 0; k--) begin
        if (window[k]) begin
          ok_o  = 1'b1;
          idx_o = CNT_W'(k);
        end
      end
    end
  end

endmodule

// File: rtl/tps_regmap.sv
// Register number = base + element index, wrapping modulo 2^REG_W.
module tps_regmap #(
  parameter int REG_W = 7,
  parameter int CNT_W = 7
) (
  input  logic [REG_W-1:0] base_i,
  input  logic [CNT_W-1:0] idx_i,
  output logic [REG_W-1:0] reg_o
);

  localparam int SUM_W = REG_W + CNT_W;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum   = {{CNT_W{1'b0}}, base_i} + {{REG_W{1'b0}}, idx_i};
    reg_o = sum[REG_W-1:0];
  end

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int MAX_VL = 64,
  parameter int REG_W  = 7,
  localparam int CNT_W = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic              src_vec_i,
  input  logic              dst_vec_i,
  input  logic [REG_W-1:0]  src_base_i,
  input  logic [REG_W-1:0]  dst_base_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  input  logic              xfer_ready_i,
  output logic              xfer_valid_o,
  output logic [IDX_W-1:0]  src_idx_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [REG_W-1:0]  src_reg_o,
  output logic [REG_W-1:0]  dst_reg_o,
  output logic              busy_o,
  output logic              done_o
);

  import tps_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // run state
  tps_state_e        state_q, state_d;
  logic [CNT_W-1:0]  vl_q;
  logic              sv_q, dv_q;
  logic [REG_W-1:0]  sbase_q, dbase_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic [CNT_W-1:0]  i_q, i_d, j_q, j_d;
  logic              cap_en, adv_en;

  // search results
  logic             s_ok, d_ok;
  logic [CNT_W-1:0] s_idx, d_idx;
  logic             fire;

  tps_scan #(.MAX_VL(MAX_VL), .CNT_W(CNT_W)) u_scan_src (
    .vec_i  (sv_q),
    .mask_i (smask_q),
    .from_i (i_q),
    .lim_i  (vl_q),
    .ok_o   (s_ok),
    .idx_o  (s_idx)
  );

  tps_scan #(.MAX_VL(MAX_VL), .CNT_W(CNT_W)) u_scan_dst (
    .vec_i  (dv_q),
    .mask_i (dmask_q),
    .from_i (j_q),
    .lim_i  (vl_q),
    .ok_o   (d_ok),
    .idx_o  (d_idx)
  );

  tps_regmap #(.REG_W(REG_W), .CNT_W(CNT_W)) u_map_src (
    .base_i (sbase_q),
    .idx_i  (s_idx),
    .reg_o  (src_reg_o)
  );

  tps_regmap #(.REG_W(REG_W), .CNT_W(CNT_W)) u_map_dst (
    .base_i (dbase_q),
    .idx_i  (d_idx),
    .reg_o  (dst_reg_o)
  );

  assign xfer_valid_o = (state_q == ST_RUN) && s_ok && d_ok;
  assign fire         = xfer_valid_o && xfer_ready_i;
  assign src_idx_o    = s_idx[IDX_W-1:0];
  assign dst_idx_o    = d_idx[IDX_W-1:0];
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FIN);

  // next state
  always_comb begin
    state_d = state_q;
    i_d     = i_q;
    j_d     = j_q;
    cap_en  = 1'b0;
    adv_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cap_en  = 1'b1;
          adv_en  = 1'b1;
          i_d     = '0;
          j_d     = '0;
        end
      end
      ST_RUN: begin
        if (!(s_ok && d_ok)) begin
          state_d = ST_FIN;
        end else if (fire) begin
          adv_en = 1'b1;
          i_d    = sv_q ? (s_idx + CNT_W'(1)) : i_q;
          if (dv_q) j_d = d_idx + CNT_W'(1);
          else      state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vl_q    <= '0;
      sv_q    <= 1'b0;
      dv_q    <= 1'b0;
      sbase_q <= '0;
      dbase_q <= '0;
      smask_q <= '0;
      dmask_q <= '0;
    end else if (cap_en) begin
      vl_q    <= vl_i;
      sv_q    <= src_vec_i;
      dv_q    <= dst_vec_i;
      sbase_q <= src_base_i;
      dbase_q <= dst_base_i;
      smask_q <= src_mask_i;
      dmask_q <= dst_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      i_q <= '0;
      j_q <= '0;
    end else if (adv_en) begin
      i_q <= i_d;
      j_q <= j_d;
    end
  end

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int MAX_VL = 64,
  parameter int REG_W  = 7,
  parameter int CNT_W  = 7,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              valid,
  input logic              ready,
  input logic              done,
  input logic [IDX_W-1:0]  src_idx,
  input logic [IDX_W-1:0]  dst_idx,
  input logic [REG_W-1:0]  src_reg,
  input logic [REG_W-1:0]  dst_reg,
  input logic [CNT_W-1:0]  vl_q,
  input logic              sv_q,
  input logic              dv_q,
  input logic [MAX_VL-1:0] smask_q,
  input logic [MAX_VL-1:0] dmask_q
);

  AST_SRC_ON_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    valid && sv_q |-> smask_q[src_idx] && ({1'b0, src_idx} < vl_q)); // R3

  AST_DST_ON_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    valid && dv_q |-> dmask_q[dst_idx] && ({1'b0, dst_idx} < vl_q)); // R4

  AST_DST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && dv_q |=> !valid || (dst_idx > $past(dst_idx))); // R4

  AST_SRC_SCALAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !sv_q |-> src_idx == '0); // R5

  AST_SCALAR_DST_END: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !dv_q |=> done && !valid); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(src_idx) && $stable(dst_idx)
                        && $stable(src_reg) && $stable(dst_reg)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9

  AST_RUN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(vl_q) && $stable(smask_q) && $stable(dmask_q)
                            && $stable(sv_q) && $stable(dv_q)); // R2

  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy && !done); // R7

endmodule

bind twin_pred_seq tps_checker #(
  .MAX_VL(MAX_VL), .REG_W(REG_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_tps_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_o),
  .valid   (xfer_valid_o),
  .ready   (xfer_ready_i),
  .done    (done_o),
  .src_idx (src_idx_o),
  .dst_idx (dst_idx_o),
  .src_reg (src_reg_o),
  .dst_reg (dst_reg_o),
  .vl_q    (vl_q),
  .sv_q    (sv_q),
  .dv_q    (dv_q),
  .smask_q (smask_q),
  .dmask_q (dmask_q)
);

// File: tb/twin_pred_seq_tb_top.sv
module twin_pred_seq_tb_top;

  localparam int MAX_VL = 64;
  localparam int REG_W  = 7;
  localparam int CNT_W  = 7;
  localparam int IDX_W  = 6;

  typedef struct packed {
    logic [6:0]  vl;
    logic        sv;
    logic        dv;
    logic        stall;
    logic        poke;
    logic [6:0]  sbase;
    logic [6:0]  dbase;
    logic [63:0] sm;
    logic [63:0] dm;
  } run_t;

  localparam int NRUNS = 10;
  localparam run_t RUNS [NRUNS] = '{
    // compress: sparse source, dense destination
    '{7'd8,  1'b1, 1'b1, 1'b0, 1'b0, 7'd120, 7'd10, 64'hA5, 64'hFF},
    // expand with stalls and a start pulse while busy
    '{7'd8,  1'b1, 1'b1, 1'b1, 1'b1, 7'd20, 7'd40, 64'hFF, 64'h5A},
    // both masks sparse
    '{7'd16, 1'b1, 1'b1, 1'b1, 1'b0, 7'd124, 7'd0, 64'h0F0F, 64'hF00F},
    // full length, all ones
    '{7'd64, 1'b1, 1'b1, 1'b1, 1'b0, 7'd100, 7'd70, {64{1'b1}}, {64{1'b1}}},
    // scalar source broadcast into masked destination
    '{7'd6,  1'b0, 1'b1, 1'b0, 1'b0, 7'd5, 7'd30, 64'h0, 64'h29},
    // extract element 4 into a scalar
    '{7'd8,  1'b1, 1'b0, 1'b0, 1'b0, 7'd60, 7'd3, 64'h10, 64'h0},
    // source bits only at or above VL: zero transfers
    '{7'd5,  1'b1, 1'b1, 1'b0, 1'b0, 7'd1, 7'd2, 64'hE0, 64'hFF},
    // scalar to scalar
    '{7'd4,  1'b0, 1'b0, 1'b1, 1'b0, 7'd9, 7'd11, 64'h0, 64'h0},
    // VL of one
    '{7'd1,  1'b1, 1'b1, 1'b0, 1'b0, 7'd127, 7'd127, 64'h1, 64'h1},
    // destination runs out first
    '{7'd64, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, 7'd64, 64'h8000_0000_0000_0001, 64'h4000_0000_0000_0000}
  };

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [CNT_W-1:0]  vl_i;
  logic              src_vec_i, dst_vec_i;
  logic [REG_W-1:0]  src_base_i, dst_base_i;
  logic [MAX_VL-1:0] src_mask_i, dst_mask_i;
  logic              xfer_ready_i;
  logic              xfer_valid_o;
  logic [IDX_W-1:0]  src_idx_o, dst_idx_o;
  logic [REG_W-1:0]  src_reg_o, dst_reg_o;
  logic              busy_o, done_o;

  int n_chk;
  int n_err;
  int exp_s [MAX_VL];
  int exp_d [MAX_VL];
  int exp_n;

  twin_pred_seq #(.MAX_VL(MAX_VL), .REG_W(REG_W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vl_i         (vl_i),
    .src_vec_i    (src_vec_i),
    .dst_vec_i    (dst_vec_i),
    .src_base_i   (src_base_i),
    .dst_base_i   (dst_base_i),
    .src_mask_i   (src_mask_i),
    .dst_mask_i   (dst_mask_i),
    .xfer_ready_i (xfer_ready_i),
    .xfer_valid_o (xfer_valid_o),
    .src_idx_o    (src_idx_o),
    .dst_idx_o    (dst_idx_o),
    .src_reg_o    (src_reg_o),
    .dst_reg_o    (dst_reg_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected schedule, worked out from R3..R7
  task automatic model(input run_t r);
    int i = 0;
    int j = 0;
    exp_n = 0;
    while (1) begin
      if (r.sv) while (i < int'(r.vl) && !r.sm[i]) i++;
      if (r.dv) while (j < int'(r.vl) && !r.dm[j]) j++;
      if (i >= int'(r.vl) || j >= int'(r.vl)) break;
      exp_s[exp_n] = i;
      exp_d[exp_n] = j;
      exp_n++;
      if (r.sv) i++;
      if (r.dv) j++;
      else break;
    end
  endtask

  task automatic do_run(input run_t r, input int tag);
    int   n     = 0;
    logic seen  = 1'b0;
    logic held  = 1'b0;
    logic rdy;
    int   h_s = 0, h_d = 0, h_rs = 0, h_rd = 0;
    model(r);
    @(negedge clk);
    start_i    = 1'b1;
    vl_i       = r.vl;
    src_vec_i  = r.sv;
    dst_vec_i  = r.dv;
    src_base_i = r.sbase;
    dst_base_i = r.dbase;
    src_mask_i = r.sm;
    dst_mask_i = r.dm;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      if (cyc == 0) start_i = 1'b0;
      if (r.poke && cyc == 1) begin
        start_i    = 1'b1;   // R2: ignored while busy
        vl_i       = 7'd3;
        src_vec_i  = 1'b0;
        dst_vec_i  = 1'b0;
        src_mask_i = '0;
        dst_mask_i = '0;
      end
      if (r.poke && cyc == 2) start_i = 1'b0;
      if (done_o) begin
        seen = 1'b1;
        break;
      end
      rdy = r.stall ? ((cyc % 3) != 1) : 1'b1;
      xfer_ready_i = rdy;
      if (held) begin
        chk(xfer_valid_o && int'(src_idx_o) == h_s && int'(dst_idx_o) == h_d
            && int'(src_reg_o) == h_rs && int'(dst_reg_o) == h_rd,
            "R8 stall hold", int'(dst_idx_o), h_d);
      end
      held = 1'b0;
      if (xfer_valid_o) begin
        if (rdy) begin
          if (n < exp_n) begin
            chk(int'(src_idx_o) == exp_s[n], r.poke ? "R2 src idx" : "R3 src idx",
                int'(src_idx_o), exp_s[n]);
            chk(int'(dst_idx_o) == exp_d[n], r.sv ? "R4 dst idx" : "R5 dst idx",
                int'(dst_idx_o), exp_d[n]);
            chk(src_reg_o == 7'(int'(r.sbase) + exp_s[n]), "R10 src reg",
                int'(src_reg_o), int'(7'(int'(r.sbase) + exp_s[n])));
            chk(dst_reg_o == 7'(int'(r.dbase) + exp_d[n]), "R10 dst reg",
                int'(dst_reg_o), int'(7'(int'(r.dbase) + exp_d[n])));
          end else begin
            chk(1'b0, "R7 extra transfer", n, exp_n);
          end
          n++;
        end else begin
          held = 1'b1;
          h_s  = int'(src_idx_o);
          h_d  = int'(dst_idx_o);
          h_rs = int'(src_reg_o);
          h_rd = int'(dst_reg_o);
        end
      end
    end
    chk(seen, "R9 done seen", int'(seen), 1);
    chk(n == exp_n, r.dv ? "R7 transfer count" : "R6 transfer count", n, exp_n);
    @(negedge clk);
    chk(!done_o && !busy_o, "R9 single pulse", int'(done_o), 0);
    xfer_ready_i = 1'b0;
    if (tag < 0) $display("unused");
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_err);
    $finish;
  end

  initial begin
    n_chk        = 0;
    n_err        = 0;
    rst_n        = 1'b0;
    start_i      = 1'b0;
    vl_i         = '0;
    src_vec_i    = 1'b0;
    dst_vec_i    = 1'b0;
    src_base_i   = '0;
    dst_base_i   = '0;
    src_mask_i   = '0;
    dst_mask_i   = '0;
    xfer_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle after reset
    chk(!busy_o && !xfer_valid_o && !done_o, "R1 reset idle",
        int'({busy_o, xfer_valid_o, done_o}), 0);

    for (int k = 0; k < NRUNS; k++) do_run(RUNS[k], k);

    // R7: a zero-transfer run still ends promptly with one done pulse
    begin
      run_t z = '{7'd64, 1'b1, 1'b1, 1'b0, 1'b0, 7'd0, 7'd0, 64'h0, {64{1'b1}}};
      do_run(z, 99);
    end

    // R1: reset in the middle of a run returns the block to idle
    @(negedge clk);
    start_i    = 1'b1;
    vl_i       = 7'd64;
    src_vec_i  = 1'b1;
    dst_vec_i  = 1'b1;
    src_mask_i = {64{1'b1}};
    dst_mask_i = {64{1'b1}};
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && xfer_valid_o, "R1 run started", int'(busy_o), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !xfer_valid_o && !done_o, "R1 reset mid-run",
        int'({busy_o, xfer_valid_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o, "R1 stays idle", int'(busy_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule